// File: doc/BRIEF.md
# Scratchpad Address Directory

Each core keeps one of these directories to record which ranges of global memory currently live in its own scratchpad. The directory has a fixed number of slots. Each slot holds a global base address, a chunk length and the scratchpad address where that chunk begins. When the runtime maps a chunk into the scratchpad, it issues an insert. When it releases the chunk, it issues a remove that names the chunk's global base.

Guarded loads and stores present their global address on the local lookup port. The directory does not only report a hit. On a match it returns the translated scratchpad address, so the access goes to the valid copy instead of the L1 cache. A second, independent lookup port serves queries from other cores, which lets an aliased guarded access be routed to this core's scratchpad. Both lookups are combinational and answer in the cycle in which the address is presented.

Top module: `spm_dir_cam`

## Requirements
- R1: After reset every slot is empty. Both lookup ports report a miss with a zero scratchpad address, and `full` is low.
- R2: An address hits a slot when the slot is valid and `base <= addr < base + len`. On a hit the returned scratchpad address is `spm_base + (addr - base)`. The last byte `base + len - 1` hits. `base + len` and `base - 1` miss.
- R3: On a miss, the hit flag is low and the returned scratchpad address is zero.
- R4: An insert takes effect at the next rising clock edge. It fills the lowest-numbered empty slot, which is also the slot a remove has freed.
- R5: A remove clears, at the next edge, every valid slot whose base equals the given address. A remove whose address matches no slot changes nothing: all earlier lookups answer as before.
- R6: When several slots cover an address, the slot with the lowest index supplies the result.
- R7: `full` is high when every slot is valid. An insert while full raises `ins_err` in the same cycle and leaves every slot unchanged.
- R8: The local and remote lookup ports are independent. Different addresses presented in the same cycle each receive their own correct answer, and equal addresses receive equal answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert command strobe |
| ins_gaddr | input | AW | Global base of the chunk to map |
| ins_len | input | LW | Chunk length in bytes |
| ins_saddr | input | SW | Scratchpad base of the chunk |
| ins_err | output | 1 | Insert rejected because the directory is full |
| rem_valid | input | 1 | Remove command strobe |
| rem_gaddr | input | AW | Global base of the chunk to unmap |
| lk_addr | input | AW | Local guarded-access address |
| lk_hit | output | 1 | Local lookup hit |
| lk_saddr | output | SW | Local diverted scratchpad address |
| rq_addr | input | AW | Remote query address |
| rq_hit | output | 1 | Remote lookup hit |
| rq_saddr | output | SW | Remote diverted scratchpad address |
| full | output | 1 | All slots occupied |

## Verification
The occupancy assertions assume that an insert and a remove are not issued in the same cycle. With both in one cycle the change in slot count is not a single step, so the stimulus never overlaps the two commands. The growth check also assumes that the runtime inserts only when the directory is not full. The bench breaks this on purpose only once, to confirm the rejection path, and that path has its own assertion. Every lookup uses chunk bases well away from the top of the address space, so the range test never wraps around.

// File: rtl/spm_dir_cam.sv
module spm_dir_cam #(
  parameter int ENTRIES = 32,
  parameter int AW      = 32,
  parameter int LW      = 16,
  parameter int SW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [AW-1:0] ins_gaddr,
  input  logic [LW-1:0] ins_len,
  input  logic [SW-1:0] ins_saddr,
  output logic          ins_err,
  input  logic          rem_valid,
  input  logic [AW-1:0] rem_gaddr,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [SW-1:0] lk_saddr,
  input  logic [AW-1:0] rq_addr,
  output logic          rq_hit,
  output logic [SW-1:0] rq_saddr,
  output logic          full
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [AW-1:0]      base_q [ENTRIES];
  logic [LW-1:0]      len_q  [ENTRIES];
  logic [SW-1:0]      spm_q  [ENTRIES];

  logic [IW-1:0] free_idx;
  logic          ins_do;

  function automatic logic [SW:0] probe(input logic [AW-1:0] a);
    logic [SW:0]   res;
    logic [AW-1:0] off;
    res = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      off = a - base_q[i];
      if (valid_q[i] && (off < AW'(len_q[i])))
        res = {1'b1, spm_q[i] + off[SW-1:0]};
    end
    return res;
  endfunction

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) free_idx = IW'(i);
  end

  assign full    = &valid_q;
  assign ins_err = ins_valid & full;
  assign ins_do  = ins_valid & ~full;

  assign {lk_hit, lk_saddr} = probe(lk_addr);
  assign {rq_hit, rq_saddr} = probe(rq_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (rem_valid && valid_q[i] && (base_q[i] == rem_gaddr))
          valid_q[i] <= 1'b0;
        if (ins_do && (free_idx == IW'(i))) begin
          valid_q[i] <= 1'b1;
          base_q[i]  <= ins_gaddr;
          len_q[i]   <= ins_len;
          spm_q[i]   <= ins_saddr;
        end
      end
    end
  end

  // R7
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && full && !rem_valid) |=> (valid_q == $past(valid_q)));

  // R4
  insert_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !full && !rem_valid) |=>
      ($countones(valid_q) == $past($countones(valid_q)) + 1));

  // R5
  remove_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_valid && !ins_valid) |=>
      ($countones(valid_q) <= $past($countones(valid_q))));

  // R8
  port_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_addr == rq_addr) |-> (lk_hit == rq_hit && lk_saddr == rq_saddr));

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_saddr == '0));

  // R1
  empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q == '0) |-> (!lk_hit && !rq_hit));
endmodule

// File: tb/spm_dir_cam_bench.sv
module spm_dir_cam_bench;
  localparam int N = 32;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        ins_valid = 0, rem_valid = 0;
  logic [31:0] ins_gaddr = 0, rem_gaddr = 0, lk_addr = 0, rq_addr = 0;
  logic [15:0] ins_len = 0, ins_saddr = 0;
  logic        ins_err, lk_hit, rq_hit, full;
  logic [15:0] lk_saddr, rq_saddr;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  spm_dir_cam u_spm_dir_cam (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_gaddr(ins_gaddr), .ins_len(ins_len),
    .ins_saddr(ins_saddr), .ins_err(ins_err),
    .rem_valid(rem_valid), .rem_gaddr(rem_gaddr),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_saddr(lk_saddr),
    .rq_addr(rq_addr), .rq_hit(rq_hit), .rq_saddr(rq_saddr),
    .full(full)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] a;
    logic [15:0] l;
    logic [15:0] s;
    logic        h;
    logic [15:0] e;
  } vec_t;

  localparam logic [1:0] LK = 2'd0, IN = 2'd1, RM = 2'd2;

  localparam vec_t VEC [11] = '{
    '{IN, 32'h1000, 16'h100, 16'h0000, 1'b0, 16'h0},
    '{IN, 32'h4000, 16'h040, 16'h0200, 1'b0, 16'h0},
    '{LK, 32'h1000, 16'h0,   16'h0,    1'b1, 16'h0000},
    '{LK, 32'h10FF, 16'h0,   16'h0,    1'b1, 16'h00FF},
    '{LK, 32'h1100, 16'h0,   16'h0,    1'b0, 16'h0000},
    '{LK, 32'h0FFF, 16'h0,   16'h0,    1'b0, 16'h0000},
    '{LK, 32'h4010, 16'h0,   16'h0,    1'b1, 16'h0210},
    '{RM, 32'h4000, 16'h0,   16'h0,    1'b0, 16'h0},
    '{LK, 32'h4010, 16'h0,   16'h0,    1'b0, 16'h0000},
    '{RM, 32'h5000, 16'h0,   16'h0,    1'b0, 16'h0},
    '{LK, 32'h1020, 16'h0,   16'h0,    1'b1, 16'h0020}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_ins(input logic [31:0] a, input logic [15:0] l, input logic [15:0] s,
                        input logic exp_err, input string req);
    @(negedge clk);
    ins_valid = 1; ins_gaddr = a; ins_len = l; ins_saddr = s;
    #2 check(req, {31'b0, ins_err}, {31'b0, exp_err});
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic do_rem(input logic [31:0] a);
    @(negedge clk);
    rem_valid = 1; rem_gaddr = a;
    @(negedge clk);
    rem_valid = 0;
  endtask

  task automatic do_lk(input logic [31:0] a, input logic h, input logic [15:0] e, input string req);
    @(negedge clk);
    lk_addr = a; rq_addr = a;
    #2;
    check(req, {15'b0, lk_hit, lk_saddr}, {15'b0, h, e});
    check(req, {15'b0, rq_hit, rq_saddr}, {15'b0, h, e});
  endtask

  initial begin
    #3000000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    do_lk(32'h1000, 1'b0, 16'h0, "R1");
    check("R1", {31'b0, full}, 32'd0);

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < 11; i++) begin
      case (VEC[i].op)
        IN: do_ins(VEC[i].a, VEC[i].l, VEC[i].s, 1'b0, "R4");
        RM: do_rem(VEC[i].a);
        default: do_lk(VEC[i].a, VEC[i].h, VEC[i].e, "R2/R3/R5");
      endcase
    end

    // R6 overlap: new chunk lands in freed slot 1, slot 0 wins
    do_ins(32'h1080, 16'h10, 16'h0800, 1'b0, "R4");
    do_lk(32'h1084, 1'b1, 16'h0084, "R6");
    do_rem(32'h1000);
    do_lk(32'h1084, 1'b1, 16'h0804, "R6");
    do_lk(32'h1020, 1'b0, 16'h0, "R5");

    // R7 fill to capacity
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    do_lk(32'h1084, 1'b0, 16'h0, "R1");
    for (int i = 0; i < N; i++)
      do_ins(32'h10000 + i * 32'h100, 16'h100, 16'(i * 16'h100), 1'b0, "R7");
    #1 check("R7", {31'b0, full}, 32'd1);
    do_ins(32'h90000, 16'h100, 16'h7000, 1'b1, "R7");
    do_lk(32'h90000, 1'b0, 16'h0, "R7");
    do_lk(32'h10000 + 31 * 32'h100 + 5, 1'b1, 16'h1F05, "R7");

    // R8 independent ports
    @(negedge clk);
    lk_addr = 32'h10205; rq_addr = 32'h10300;
    #2;
    check("R8", {15'b0, lk_hit, lk_saddr}, {15'b0, 1'b1, 16'h0205});
    check("R8", {15'b0, rq_hit, rq_saddr}, {15'b0, 1'b1, 16'h0300});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule